// File: doc/BRIEF.md
# Pseudo-Immediate Operand Extractor

This block supplies immediate operands that live as data bytes inside 256-bit instruction blocks rather than inside the instruction word. It holds two block registers: the block now executing and a saved copy of the block executed before it. An operand read names one byte by a 5-bit pointer, picks either the current or the saved block, and asks for 1, 2, 4 or 8 bytes. The bytes are gathered little-endian from the pointed byte upward and widened to 64 bits by zero or sign extension. Because the saved block can be read, space reserved at the end of one block can feed an instruction in the following block.

A block-advance strobe loads a new block into the current register and, on the same edge, moves the old current block into the saved register. A flush, for example after a taken branch, marks the saved block invalid, since the block executed before the branch target is no longer the previous block in program order. Reads are purely combinational from the two registers and add no latency. A read that runs past the last byte, or that targets an invalid saved block, raises an error flag and returns zero.

Top module: `pimm_extract`

## Requirements
- R1: After reset both block registers hold zero and the saved block is invalid, so a current-block read returns zero and a saved-block read raises the stale flag.
- R2: Length code 0, 1, 2, 3 selects 1, 2, 4, 8 bytes; byte n of a block is bits [8n+7:8n] of the loaded block, and result byte i is block byte ptr+i.
- R3: With the sign-extend input low the result is zero above the selected bytes; with it high those bits copy the top bit of the highest selected byte.
- R4: When pointer plus byte count exceeds 32, the range error output is high and the result is zero.
- R5: With the block-select input high the bytes come from the saved block, with it low from the current block.
- R6: On a clock edge with the advance strobe high, the input block becomes the current block, the former current block becomes the saved block, and the saved block becomes valid unless a flush is also present.
- R7: On a clock edge with flush high the saved block becomes invalid; a flush together with an advance still loads both registers but leaves the saved block invalid.
- R8: A read of an invalid saved block raises the stale error output and returns zero.
- R9: The result follows the inputs in the same cycle from the stored registers; without advance or flush both registers and the valid state are unchanged, whatever the block input carries.
- R10: With the read-enable input low the result is zero and both error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Block-advance strobe |
| flush_i | input | 1 | Invalidate the saved block |
| blk_i | input | 256 | Incoming instruction block |
| rd_en_i | input | 1 | Operand read enable |
| rd_prev_i | input | 1 | 1 reads the saved block, 0 the current block |
| rd_ptr_i | input | 5 | Starting byte within the block |
| rd_len_i | input | 2 | Length code: 1, 2, 4 or 8 bytes |
| rd_sext_i | input | 1 | 1 sign-extends, 0 zero-extends |
| imm_o | output | 64 | Extended operand |
| err_range_o | output | 1 | Read runs past byte 31 |
| err_stale_o | output | 1 | Read of an invalid saved block |

## Verification
An operand read and a block advance can fall in the same cycle, and so can an advance and a flush. The bench issues reads in the cycle the advance strobe is high and judges them against the registers as they stood before the edge, then reads both blocks in the next cycle to see the shift. It also raises flush and advance together and expects the new current block to be readable while any saved-block read reports stale, until a later plain advance revalidates it.

// File: rtl/pimm_pkg.sv
package pimm_pkg;
  localparam int unsigned DEF_BLK_BYTES = 32;
  localparam int unsigned DEF_IMM_BYTES = 8;

  // Number of bytes requested by a length code (power of two).
  function automatic int unsigned code_to_bytes(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // True when a read of nbytes starting at ptr stays inside the block.
  function automatic logic fits_block(input int unsigned ptr,
                                      input int unsigned nbytes,
                                      input int unsigned blk_bytes);
    return (ptr + nbytes) <= blk_bytes;
  endfunction
endpackage

// File: rtl/pimm_blk_store.sv
module pimm_blk_store #(
  parameter int unsigned BLK_BYTES = pimm_pkg::DEF_BLK_BYTES,
  localparam int unsigned BLK_W = BLK_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             flush_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [BLK_W-1:0] cur_o,
  output logic [BLK_W-1:0] sav_o,
  output logic             sav_vld_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_o     <= '0;
      sav_o     <= '0;
      sav_vld_o <= 1'b0;
    end else begin
      if (adv_i) begin
        sav_o <= cur_o;
        cur_o <= blk_i;
      end
      if (flush_i)    sav_vld_o <= 1'b0;
      else if (adv_i) sav_vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pimm_byte_sel.sv
module pimm_byte_sel #(
  parameter int unsigned BLK_BYTES = pimm_pkg::DEF_BLK_BYTES,
  parameter int unsigned IMM_BYTES = pimm_pkg::DEF_IMM_BYTES,
  localparam int unsigned BLK_W = BLK_BYTES * 8,
  localparam int unsigned IMM_W = IMM_BYTES * 8,
  localparam int unsigned PTR_W = $clog2(BLK_BYTES),
  localparam int unsigned IDX_W = PTR_W + 1,
  localparam int unsigned CNT_W = $clog2(IMM_BYTES) + 1
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [CNT_W-1:0] nbytes_i,
  output logic [IMM_W-1:0] raw_o
);
  logic [7:0] blk_byte [BLK_BYTES];

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_split
    assign blk_byte[b] = blk_i[b*8 +: 8];
  end

  for (genvar k = 0; k < IMM_BYTES; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic             in_blk;
    logic             wanted;
    assign idx    = {1'b0, ptr_i} + IDX_W'(k);
    assign in_blk = idx < IDX_W'(BLK_BYTES);
    assign wanted = CNT_W'(k) < nbytes_i;
    assign raw_o[k*8 +: 8] = (in_blk && wanted) ? blk_byte[idx[PTR_W-1:0]] : 8'h00;
  end
endmodule

// File: rtl/pimm_extend.sv
module pimm_extend #(
  parameter int unsigned IMM_BYTES = pimm_pkg::DEF_IMM_BYTES,
  localparam int unsigned IMM_W = IMM_BYTES * 8,
  localparam int unsigned LEN_W = $clog2($clog2(IMM_BYTES) + 1),
  localparam int unsigned NCODE = $clog2(IMM_BYTES) + 1,
  localparam int unsigned CNT_W = $clog2(IMM_BYTES) + 1
) (
  input  logic [IMM_W-1:0] raw_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             sext_i,
  output logic [IMM_W-1:0] ext_o
);
  logic top_bit;

  always_comb begin
    top_bit = 1'b0;
    for (int j = 0; j < NCODE; j++) begin
      if (len_i == LEN_W'(j)) top_bit = raw_i[8 * (1 << j) - 1];
    end
  end

  for (genvar k = 0; k < IMM_BYTES; k++) begin : g_fill
    logic upper;
    assign upper = CNT_W'(k) >= nbytes_i;
    assign ext_o[k*8 +: 8] = upper ? {8{sext_i & top_bit}} : raw_i[k*8 +: 8];
  end
endmodule

// File: rtl/pimm_extract.sv
module pimm_extract #(
  parameter int unsigned BLK_BYTES = pimm_pkg::DEF_BLK_BYTES,
  parameter int unsigned IMM_BYTES = pimm_pkg::DEF_IMM_BYTES,
  localparam int unsigned BLK_W = BLK_BYTES * 8,
  localparam int unsigned IMM_W = IMM_BYTES * 8,
  localparam int unsigned PTR_W = $clog2(BLK_BYTES),
  localparam int unsigned LEN_W = $clog2($clog2(IMM_BYTES) + 1),
  localparam int unsigned CNT_W = $clog2(IMM_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             flush_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             rd_en_i,
  input  logic             rd_prev_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  input  logic [LEN_W-1:0] rd_len_i,
  input  logic             rd_sext_i,
  output logic [IMM_W-1:0] imm_o,
  output logic             err_range_o,
  output logic             err_stale_o
);
  // Named internal events, visible to the bound checker.
  logic [BLK_W-1:0] cur_blk_w;
  logic [BLK_W-1:0] sav_blk_w;
  logic             sav_vld_w;
  logic [BLK_W-1:0] src_blk_w;
  logic [CNT_W-1:0] nbytes_w;
  logic [IMM_W-1:0] raw_w;
  logic [IMM_W-1:0] ext_w;
  logic             fits_w;
  logic             stale_w;

  pimm_blk_store #(.BLK_BYTES(BLK_BYTES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv_i),
    .flush_i  (flush_i),
    .blk_i    (blk_i),
    .cur_o    (cur_blk_w),
    .sav_o    (sav_blk_w),
    .sav_vld_o(sav_vld_w)
  );

  assign src_blk_w = rd_prev_i ? sav_blk_w : cur_blk_w;
  assign nbytes_w  = CNT_W'(pimm_pkg::code_to_bytes(32'(rd_len_i)));
  assign fits_w    = pimm_pkg::fits_block(32'(rd_ptr_i), 32'(nbytes_w), BLK_BYTES);
  assign stale_w   = rd_prev_i && !sav_vld_w;

  pimm_byte_sel #(.BLK_BYTES(BLK_BYTES), .IMM_BYTES(IMM_BYTES)) u_sel (
    .blk_i   (src_blk_w),
    .ptr_i   (rd_ptr_i),
    .nbytes_i(nbytes_w),
    .raw_o   (raw_w)
  );

  pimm_extend #(.IMM_BYTES(IMM_BYTES)) u_ext (
    .raw_i   (raw_w),
    .len_i   (rd_len_i),
    .nbytes_i(nbytes_w),
    .sext_i  (rd_sext_i),
    .ext_o   (ext_w)
  );

  always_comb begin
    err_range_o = rd_en_i && !fits_w;
    err_stale_o = rd_en_i && stale_w;
    imm_o       = (rd_en_i && fits_w && !stale_w) ? ext_w : '0;
  end
endmodule

// File: rtl/pimm_extract_chk.sv
module pimm_extract_chk #(
  parameter int unsigned BLK_BYTES = pimm_pkg::DEF_BLK_BYTES,
  parameter int unsigned IMM_BYTES = pimm_pkg::DEF_IMM_BYTES,
  localparam int unsigned BLK_W = BLK_BYTES * 8,
  localparam int unsigned IMM_W = IMM_BYTES * 8,
  localparam int unsigned LEN_W = $clog2($clog2(IMM_BYTES) + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv_i,
  input logic             flush_i,
  input logic [BLK_W-1:0] blk_i,
  input logic             rd_en_i,
  input logic             rd_prev_i,
  input logic [LEN_W-1:0] rd_len_i,
  input logic             rd_sext_i,
  input logic [IMM_W-1:0] imm_o,
  input logic             err_range_o,
  input logic             err_stale_o,
  input logic [BLK_W-1:0] cur_blk_w,
  input logic [BLK_W-1:0] sav_blk_w,
  input logic             sav_vld_w
);
  assert_zext_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !rd_sext_i && rd_len_i == '0) |-> (imm_o[IMM_W-1:8] == '0));

  assert_range_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_range_o |-> (imm_o == '0));

  assert_advance_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (cur_blk_w == $past(blk_i)) && (sav_blk_w == $past(cur_blk_w)));

  assert_flush_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !sav_vld_w);

  assert_stale_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> ((rd_en_i && rd_prev_i) |-> (err_stale_o && imm_o == '0)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !flush_i) |=> ($stable(cur_blk_w) && $stable(sav_blk_w) && $stable(sav_vld_w)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (imm_o == '0 && !err_range_o && !err_stale_o));
endmodule

bind pimm_extract pimm_extract_chk #(.BLK_BYTES(BLK_BYTES), .IMM_BYTES(IMM_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adv_i      (adv_i),
  .flush_i    (flush_i),
  .blk_i      (blk_i),
  .rd_en_i    (rd_en_i),
  .rd_prev_i  (rd_prev_i),
  .rd_len_i   (rd_len_i),
  .rd_sext_i  (rd_sext_i),
  .imm_o      (imm_o),
  .err_range_o(err_range_o),
  .err_stale_o(err_stale_o),
  .cur_blk_w  (cur_blk_w),
  .sav_blk_w  (sav_blk_w),
  .sav_vld_w  (sav_vld_w)
);

// File: tb/pimm_extract_tb.sv
`timescale 1ns/1ps
module pimm_extract_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         adv_i = 1'b0;
  logic         flush_i = 1'b0;
  logic [255:0] blk_i = '0;
  logic         rd_en_i = 1'b0;
  logic         rd_prev_i = 1'b0;
  logic [4:0]   rd_ptr_i = '0;
  logic [1:0]   rd_len_i = '0;
  logic         rd_sext_i = 1'b0;
  logic [63:0]  imm_o;
  logic         err_range_o;
  logic         err_stale_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [255:0] m_cur = '0;
  logic [255:0] m_sav = '0;
  bit           m_vld = 0;

  always #2.5 clk = ~clk;

  pimm_extract u_dut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .flush_i(flush_i), .blk_i(blk_i),
    .rd_en_i(rd_en_i), .rd_prev_i(rd_prev_i), .rd_ptr_i(rd_ptr_i),
    .rd_len_i(rd_len_i), .rd_sext_i(rd_sext_i),
    .imm_o(imm_o), .err_range_o(err_range_o), .err_stale_o(err_stale_o)
  );

  function automatic logic [255:0] mk_blk(input int seed);
    logic [255:0] b;
    for (int n = 0; n < 32; n++) b[8*n +: 8] = 8'(seed * 53 + n * 29 + (n % 2) * 128);
    return b;
  endfunction

  task automatic expect_read(output logic [63:0] imm, output bit er, output bit es);
    int nb;
    int p;
    logic [255:0] src;
    imm = '0; er = 0; es = 0;
    if (!rd_en_i) return;
    nb  = 1 << rd_len_i;
    p   = int'(rd_ptr_i);
    src = rd_prev_i ? m_sav : m_cur;
    es  = rd_prev_i && !m_vld;
    er  = (p + nb) > 32;
    if (es || er) return;
    for (int i = 0; i < nb; i++) imm[8*i +: 8] = src[8*(p+i) +: 8];
    if (rd_sext_i && nb < 8 && imm[8*nb-1])
      for (int i = nb; i < 8; i++) imm[8*i +: 8] = 8'hFF;
  endtask

  // One cycle: drive after the falling edge, compare, then apply the edge to the model.
  task automatic cyc(input bit adv, input bit fl, input logic [255:0] blk,
                     input bit en, input bit prev, input int ptr, input int len,
                     input bit sx, input string tag);
    logic [63:0] e_imm;
    bit e_er, e_es;
    @(negedge clk);
    adv_i = adv; flush_i = fl; blk_i = blk;
    rd_en_i = en; rd_prev_i = prev; rd_ptr_i = 5'(ptr); rd_len_i = 2'(len); rd_sext_i = sx;
    #1;
    expect_read(e_imm, e_er, e_es);
    checks++;
    if (imm_o !== e_imm || err_range_o !== e_er || err_stale_o !== e_es) begin
      errors++;
      $display("FAIL %s ptr=%0d len=%0d prev=%0b sx=%0b: imm=%h rng=%b stale=%b expected imm=%h rng=%b stale=%b",
               tag, ptr, len, prev, sx, imm_o, err_range_o, err_stale_o, e_imm, e_er, e_es);
    end
    @(posedge clk);
    if (rst_n) begin
      if (adv) begin m_sav = m_cur; m_cur = blk; end
      if (fl) m_vld = 0; else if (adv) m_vld = 1;
    end
  endtask

  task automatic sweep(input bit prev, input string tag);
    for (int p = 0; p < 32; p++)
      for (int l = 0; l < 4; l++)
        for (int s = 0; s < 2; s++)
          cyc(0, 0, mk_blk(99), 1, prev, p, l, s[0], tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset contents, R10: idle outputs
    cyc(0, 0, '0, 1, 0, 0, 3, 1, "R1 current after reset");
    cyc(0, 0, '0, 1, 1, 4, 2, 0, "R1 saved stale after reset");
    cyc(0, 0, mk_blk(7), 0, 1, 30, 3, 1, "R10 read disabled");

    // R6: first advance, then R2/R3/R4 sweep of current block
    cyc(1, 0, mk_blk(1), 0, 0, 0, 0, 0, "R6 advance");
    sweep(0, "R2/R3/R4 current block");

    // R5/R6: second advance, sweep saved block
    cyc(1, 0, mk_blk(2), 1, 0, 8, 2, 0, "R6 advance with read");
    sweep(1, "R5/R6 saved block");

    // R9: read in the advance cycle sees pre-edge contents, then the shift
    cyc(1, 0, mk_blk(3), 1, 1, 24, 3, 1, "R9 read during advance");
    cyc(0, 0, mk_blk(4), 1, 1, 24, 3, 1, "R6 shifted saved");
    cyc(0, 0, mk_blk(4), 1, 0, 24, 3, 1, "R6 shifted current");

    // R9: hold with a changing block input
    for (int i = 0; i < 6; i++)
      cyc(0, 0, mk_blk(40 + i), 1, i % 2, i * 5, i % 4, i % 2, "R9 hold");

    // R7/R8: flush alone
    cyc(0, 1, mk_blk(5), 1, 1, 0, 0, 0, "R7 read in flush cycle");
    cyc(0, 0, mk_blk(5), 1, 1, 0, 0, 0, "R8 stale after flush");
    cyc(0, 0, mk_blk(5), 1, 0, 16, 3, 0, "R7 current kept after flush");
    cyc(0, 0, mk_blk(5), 1, 1, 31, 3, 0, "R8 stale with range");

    // R7: flush together with advance
    cyc(1, 1, mk_blk(6), 1, 0, 4, 2, 1, "R7 flush plus advance");
    cyc(0, 0, mk_blk(0), 1, 0, 4, 2, 1, "R7 new current readable");
    cyc(0, 0, mk_blk(0), 1, 1, 4, 2, 1, "R7 saved stays invalid");
    cyc(1, 0, mk_blk(8), 1, 1, 0, 3, 0, "R6 plain advance");
    cyc(0, 0, mk_blk(0), 1, 1, 0, 3, 0, "R6 saved valid again");
    cyc(0, 0, mk_blk(0), 1, 1, 28, 2, 1, "R4 last word saved");
    cyc(0, 0, mk_blk(0), 1, 1, 29, 2, 1, "R4 one past end");

    // R10: idle with garbage
    cyc(0, 0, '1, 0, 0, 31, 3, 1, "R10 idle");

    // R1: reset again clears both registers
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk);
    m_cur = '0; m_sav = '0; m_vld = 0;
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, '0, 1, 0, 0, 3, 0, "R1 current after second reset");
    cyc(0, 0, '0, 1, 1, 0, 3, 0, "R1 saved after second reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule